// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory can accept normal traffic. Out of reset it drives COMMAND INHIBIT and waits for a start pulse. Once started, it first holds NOP for a power-up window of programmable length. It then precharges all banks and issues a configurable number of AUTO REFRESH commands. Last, it writes the mode register with a word captured at start, and raises a sticky ready flag. Clock enable and all data mask lines stay high throughout.

Each command occupies exactly one cycle. A programmable number of NOP cycles follows each command: one gap after the precharge, one after each refresh and one after the mode load. All command pins are decoded from one registered state. A controller that takes over the bus after the ready flag therefore sees a clean NOP on the last cycle the sequencer drives.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low (asynchronous), the bus shows COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n}=1111), with ba=0, addr=0 and init_done=0.
- R2: After reset and before start is sampled high, COMMAND INHIBIT is held.
- R3: The rising clock edge that samples start high begins the power-up window. From the next cycle on, exactly WAIT_CYC cycles of NOP (0111) are driven.
- R4: The cycle after the window carries PRECHARGE (0010), with addr bit AP_BIT set, every other addr bit 0, and ba=0.
- R5: GAP_RP NOP cycles follow the precharge, and then the first AUTO REFRESH is issued.
- R6: REF_CNT AUTO REFRESH commands (0001, addr=0, ba=0) are issued, each followed by GAP_RC NOP cycles. A REF_CNT below 2 is raised to 2.
- R7: Next comes one LOAD MODE cycle (0000), with ba=0 and addr equal to the mode_word sampled at the start edge. Later changes of mode_word have no effect.
- R8: GAP_MRD NOP cycles follow the mode load. init_done rises in the next cycle and then stays high, with NOP on the bus, until reset.
- R9: cke is 1 and every dqm bit is 1 in every cycle.
- R10: A start pulse that arrives while the sequence runs, or after it has finished, changes nothing.
- R11: Asserting rst_n at any point aborts the sequence. A later start runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when sampled high in idle |
| mode_word | input | ROW_W | Mode register value, captured at start |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | DQM_W | Data masks, held high |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Address bus |
| init_done | output | 1 | Sticky ready flag |

## Verification
All command pins are a decode of one state register, so a wrong state or timer value shows on the bus in the very cycle it occurs. It appears either as a command at the wrong cycle offset from the start edge, or as a NOP where a command should be. A bad refresh count shifts the mode load by whole refresh periods. A stale mode capture shows up only in the addr value of the single LOAD MODE cycle. The bench compares every cycle from start until several cycles past ready against an offset-indexed model, with start and mode_word toggled at random during the run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRC,
    ST_LMR,
    ST_TMRD,
    ST_DONE
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_INHIBIT = 4'b1111;
  localparam logic [3:0] CMD_NOP     = 4'b0111;
  localparam logic [3:0] CMD_PRE     = 4'b0010;
  localparam logic [3:0] CMD_REF     = 4'b0001;
  localparam logic [3:0] CMD_LMR     = 4'b0000;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned atleast(int unsigned v, int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
  parameter int unsigned TARGET = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic reached
);

  localparam int unsigned CW = $clog2(TARGET + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reached = (cnt_q == CW'(TARGET));

endmodule

// File: rtl/sdram_init_cmdenc.sv
module sdram_init_cmdenc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned AP_BIT = 10
) (
  input  seq_state_t       state,
  input  logic [ROW_W-1:0] mode_val,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);

  logic [3:0] cmd;

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    unique case (state)
      ST_IDLE: cmd = CMD_INHIBIT;
      ST_PRE: begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_LMR: begin
        cmd  = CMD_LMR;
        addr = mode_val;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 16600,
  parameter int unsigned REF_CNT  = 2,
  parameter int unsigned GAP_RP   = 3,
  parameter int unsigned GAP_RC   = 10,
  parameter int unsigned GAP_MRD  = 2,
  parameter int unsigned ROW_W    = 13,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned DQM_W    = 4,
  parameter int unsigned AP_BIT   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] mode_word,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             cke,
  output logic [DQM_W-1:0] dqm,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);

  localparam int unsigned WAIT_USE = atleast(WAIT_CYC, 1);
  localparam int unsigned REF_USE  = atleast(REF_CNT, 2);
  localparam int unsigned RP_USE   = atleast(GAP_RP, 1);
  localparam int unsigned RC_USE   = atleast(GAP_RC, 1);
  localparam int unsigned MRD_USE  = atleast(GAP_MRD, 1);
  localparam int unsigned TMR_MAX  = umax(WAIT_USE, umax(RP_USE, umax(RC_USE, MRD_USE)));
  localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);

  seq_state_t       state_q, state_d;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             ref_clr, ref_inc, ref_reached;
  logic [ROW_W-1:0] mode_q;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_clr  = 1'b0;
    ref_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(WAIT_USE - 1);
          ref_clr  = 1'b1;
        end
      end
      ST_WAIT: if (tmr_expired) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_TRP;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RP_USE - 1);
      end
      ST_TRP: if (tmr_expired) state_d = ST_REF;
      ST_REF: begin
        state_d  = ST_TRC;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RC_USE - 1);
        ref_inc  = 1'b1;
      end
      ST_TRC: if (tmr_expired) state_d = ref_reached ? ST_LMR : ST_REF;
      ST_LMR: begin
        state_d  = ST_TMRD;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(MRD_USE - 1);
      end
      ST_TMRD: if (tmr_expired) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) mode_q <= mode_word;
    end
  end

  sdram_init_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_init_refcnt #(.TARGET(REF_USE)) u_refcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ref_clr),
    .inc     (ref_inc),
    .reached (ref_reached)
  );

  sdram_init_cmdenc #(.ROW_W(ROW_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_enc (
    .state    (state_q),
    .mode_val (mode_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .addr     (addr)
  );

  assign cke       = 1'b1;
  assign dqm       = '1;
  assign init_done = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned REF_CNT = 2,
  parameter int unsigned ROW_W   = 13,
  parameter int unsigned BA_W    = 2,
  parameter int unsigned AP_BIT  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr,
  input logic             init_done
);

  localparam int unsigned REF_MIN = (REF_CNT < 2) ? 2 : REF_CNT;

  logic [3:0] cmd;
  logic       seen_pre, seen_lmr;
  logic [7:0] ref_n;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_pre <= 1'b0;
      seen_lmr <= 1'b0;
      ref_n    <= '0;
    end else begin
      if (cmd == 4'b0010) seen_pre <= 1'b1;
      if (cmd == 4'b0000) seen_lmr <= 1'b1;
      if (cmd == 4'b0001 && ref_n != 8'hFF) ref_n <= ref_n + 8'd1;
    end
  end

  p_inhibit_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!seen_pre && ref_n == 8'd0 && !init_done));
  p_pre_all_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (addr[AP_BIT] && ba == '0));
  p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |=> (cmd == 4'b0111));
  p_ref_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |-> seen_pre);
  p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |=> (cmd == 4'b0111));
  p_lmr_after_refs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (ref_n >= 8'(REF_MIN)));
  p_lmr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |=> (cmd == 4'b0111 && !init_done));
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_done_after_lmr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (seen_lmr && cmd == 4'b0111));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .REF_CNT (REF_CNT),
  .ROW_W   (ROW_W),
  .BA_W    (BA_W),
  .AP_BIT  (AP_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam int W    = 37;
  localparam int RC   = 3;
  localparam int GRP  = 2;
  localparam int GRC  = 5;
  localparam int GMRD = 2;
  localparam int ROWW = 13;
  localparam int BAW  = 2;
  localparam int DQMW = 4;
  localparam int AP   = 10;
  localparam int LM   = W + 1 + GRP + RC * (1 + GRC);
  localparam int RDY  = LM + GMRD + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [ROWW-1:0] mode_word = '0;
  logic            cs_n, ras_n, cas_n, we_n, cke, init_done;
  logic [DQMW-1:0] dqm;
  logic [BAW-1:0]  ba;
  logic [ROWW-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .WAIT_CYC(W), .REF_CNT(RC), .GAP_RP(GRP), .GAP_RC(GRC), .GAP_MRD(GMRD),
    .ROW_W(ROWW), .BA_W(BAW), .DQM_W(DQMW), .AP_BIT(AP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .dqm(dqm), .ba(ba), .addr(addr), .init_done(init_done)
  );

  function automatic logic [3:0] exp_cmd(int idx);
    if (idx < W) return 4'b0111;
    if (idx == W) return 4'b0010;
    if (idx < W + 1 + GRP) return 4'b0111;
    if (idx < LM) begin
      if (((idx - (W + 1 + GRP)) % (1 + GRC)) == 0) return 4'b0001;
      return 4'b0111;
    end
    if (idx == LM) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [ROWW-1:0] exp_addr(int idx, logic [ROWW-1:0] mw);
    if (idx == W) return ROWW'(1) << AP;
    if (idx == LM) return mw;
    return '0;
  endfunction

  function automatic string tag_of(int idx);
    if (idx < W) return "R3";
    if (idx == W) return "R4";
    if (idx < W + 1 + GRP) return "R5";
    if (idx < LM) return "R6";
    if (idx == LM) return "R7";
    return "R8";
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_inhibit(string tag);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, tag, "inhibit cmd", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk(ba == '0 && addr == '0, tag, "idle ba/addr", {ba, addr}, 0);
    chk(init_done == 1'b0, tag, "idle done", init_done, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    #1;
    chk_inhibit("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One run: idle for pre cycles, start, then compare every cycle.
  task automatic run_seq(int pre, logic [ROWW-1:0] mw, bit noise, int abort_at);
    do_reset();
    for (int i = 0; i < pre; i++) begin
      chk_inhibit("R2");
      @(negedge clk);
    end
    start = 1'b1;
    mode_word = mw;
    @(negedge clk);
    for (int idx = 0; idx < RDY + 6; idx++) begin
      start = noise ? 1'($urandom) : 1'b0;       // R10 stray starts
      if (noise) mode_word = ROWW'($urandom);      // R7 later changes ignored
      if (idx == abort_at) begin
        rst_n = 1'b0;
        #1;
        chk_inhibit("R11");
        @(negedge clk);
        rst_n = 1'b1;
        start = 1'b0;
        @(negedge clk);
        chk_inhibit("R11");
        return;
      end
      chk({cs_n, ras_n, cas_n, we_n} == exp_cmd(idx), tag_of(idx), "cmd",
          {cs_n, ras_n, cas_n, we_n}, exp_cmd(idx));
      chk(addr == exp_addr(idx, mw) && ba == '0, tag_of(idx), "ba/addr",
          {ba, addr}, exp_addr(idx, mw));
      chk(init_done == (idx >= RDY), tag_of(idx), "init_done", init_done, (idx >= RDY));
      chk(cke == 1'b1 && dqm == '1, "R9", "cke/dqm", {cke, dqm}, {1'b1, {DQMW{1'b1}}});
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk_inhibit("R1");
    rst_n = 1'b1;
    // Directed corners
    run_seq(0, 13'h0033, 1'b0, -1);
    run_seq(4, 13'h1FFF, 1'b1, -1);
    run_seq(2, 13'h0000, 1'b1, W / 2);          // R11 abort in the wait
    run_seq(1, 13'h0A5A, 1'b0, W);              // R11 abort at precharge
    run_seq(3, 13'h1234, 1'b1, LM);             // R11 abort at mode load
    run_seq(0, 13'h0777, 1'b1, -1);             // R11 full rerun after abort
    // Random runs
    for (int n = 0; n < 8; n++) begin
      int ab;
      ab = (($urandom % 3) == 0) ? int'($urandom % RDY) : -1;
      run_seq(int'($urandom % 12), ROWW'($urandom), 1'($urandom), ab);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule